// File: doc/BRIEF.md
# Buffered Serial Transceiver with Hardware Handshake

This block is an asynchronous serial transceiver. It sends and receives 8-bit characters as 8N1 frames at 16x oversampling, with a 16-entry queue on each side. A small register port gives access to a data window, a status byte and a control byte. An external divisor input sets the oversampling tick. A write to the data window queues a character for transmission. A read of the data window pops the oldest received character.

Flow control uses two cross-connected signals. The ready-to-receive output tells the far end whether one more frame can be accepted. The clear-to-send input is checked by the local transmitter only before each start bit. A line break and a receive overrun are also reported through two sticky flags that are set as soon as the event happens. These flags do not wait for the affected character to reach the head of the receive queue. Software can therefore react without first draining the queue.

Register map: address 0 is data, address 1 is status, address 2 is control. Control bit 0 enables the queues; when it is cleared, each queue holds a single character. Control bits 4, 5, 6 and 7 are interrupt masks for receive-ready, transmit-threshold, immediate break and immediate overrun. Status bits: bit 0 receive-ready, bit 1 transmitter-empty (queue empty and shifter idle), bit 2 transmit-threshold, bit 3 framing error of the head character, bit 4 break of the head character, bit 5 immediate break, bit 6 immediate overrun, bit 7 transmit queue full. Bits 2, 5 and 6 are cleared by writing 1 to them at address 1. One bit lasts 16 × (divisor + 1) clock cycles.

Top module: `fc_uart`

## Requirements
- R1: After reset, tx_o and rtr_o are 1, irq_o is 0, and the status byte reads 0x06 (transmitter-empty and transmit-threshold set).
- R2: Each transmitted frame is one low start bit, then eight data bits LSB first, then one high stop bit. Every bit lasts 16 × (divisor + 1) clocks, and the line idles high.
- R3: Each received frame is queued. Status bit 0 shows that a character is waiting, and reads at address 0 return characters in arrival order.
- R4: A low pulse on rx_i that has ended by the middle of the start bit is discarded, and no character is queued.
- R5: A break (rx_i low through the stop bit position with all-zero data) sets status bit 5 when the frame ends, even when earlier characters are still queued. Status bits 4 and 3 (break, framing error) become 1 only when the break character is at the head of the queue. The break character reads as 0x00.
- R6: A frame that completes while the receive queue is full is discarded and sets status bit 6. The queued characters are kept intact and in order.
- R7: Status bits 5 and 6 stay set until 1 is written to that bit position at address 1. Reading the queue does not clear them.
- R8: With the queues enabled, rtr_o stays 1 while the receiver has room. It falls at the validated start bit of the frame that will fill the last free slot, and rises again once a character is read.
- R9: With the queues disabled, rtr_o falls at each validated start bit and stays 0 until the received character is read.
- R10: The transmitter starts a frame only while cts_i is 1. If cts_i falls during a frame, that frame still completes.
- R11: The transmit queue holds 16 characters. Status bit 7 is 1 when the queue is full, and a write to a full queue is dropped. Status bit 1 returns to 1 after the last frame has been sent.
- R12: Once status bit 2 is cleared by software, it stays 0 until at least 8 transmit slots are empty.
- R13: irq_o is the OR of status bits 0, 2, 5 and 6, each gated by its mask in control bits 4, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| divisor | input | DIV_W | Oversampling tick period minus one, in clocks |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; at address 0 it pops the receive queue |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| cts_i | input | 1 | Clear-to-send from the far end |
| rtr_o | output | 1 | Ready-to-receive to the far end |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties check several rules on every cycle: the line is high whenever the transmitter is idle, every frame start follows a cycle with cts_i high, and rtr_o is low whenever the receive queue is at capacity. They also check that the queue occupancy never grows past the capacity, both on a receive overrun and on a write to a full transmit queue, and that the immediate break flag holds until its clear is written. Other behaviour depends on complete serial sequences and only the bench scenarios can show it. This covers bit order and bit timing, rejection of a short start glitch, rtr_o falling at the start of the frame that fills the last slot, the delay before the head-of-queue break and framing flags appear, the hysteresis of the threshold flag, and a frame continuing after cts_i drops mid-frame.

// File: rtl/fc_uart.sv
module fc_uart #(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             rx_i,
  output logic             tx_o,
  input  logic             cts_i,
  output logic             rtr_o,
  output logic             irq_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DEPTH / 2;
  localparam int OW   = $clog2(OVS);
  localparam int MID  = OVS / 2 - 1;

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_STOP, R_WAIT} rx_st_t;

  logic [7:0]       ctrl;
  logic [CW-1:0]    cap;
  logic [DIV_W-1:0] bcnt;
  logic             tick;

  assign cap  = ctrl[0] ? CW'(DEPTH) : CW'(1);
  assign tick = (bcnt == divisor);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= tick ? '0 : bcnt + 1'b1;

  // register strobes
  logic wr_data, wr_stat, wr_ctrl, rd_data;
  assign wr_data = reg_wr && reg_addr == 2'd0;
  assign wr_stat = reg_wr && reg_addr == 2'd1;
  assign wr_ctrl = reg_wr && reg_addr == 2'd2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl <= 8'h01;
    else if (wr_ctrl) ctrl <= reg_wdata;

  // transmit queue
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_full, tx_push, tx_start, tx_busy;

  assign tx_full  = tx_cnt >= cap;
  assign tx_push  = wr_data && !tx_full;
  assign tx_start = !tx_busy && tx_cnt != '0 && cts_i;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push)  tx_wp <= tx_wp + 1'b1;
      if (tx_start) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_start);
    end

  // transmit shifter
  logic [8:0]    tx_sr;
  logic [3:0]    tx_bit;
  logic [OW-1:0] tx_tc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_o <= 1'b1; tx_sr <= '1; tx_bit <= '0; tx_tc <= '0;
    end else if (tx_start) begin
      tx_busy <= 1'b1; tx_o <= 1'b0; tx_sr <= {1'b1, tx_mem[tx_rp]};
      tx_bit  <= '0;   tx_tc <= '0;
    end else if (tx_busy && tick) begin
      if (tx_tc == OW'(OVS - 1)) begin
        tx_tc <= '0;
        if (tx_bit == 4'd9) tx_busy <= 1'b0;
        else begin
          tx_o   <= tx_sr[0];
          tx_sr  <= {1'b1, tx_sr[8:1]};
          tx_bit <= tx_bit + 1'b1;
        end
      end else tx_tc <= tx_tc + 1'b1;
    end

  AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o); // R2
  AST_TX_START_CTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(cts_i)); // R10
  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_start && !wr_ctrl) |=> tx_cnt == $past(tx_cnt)); // R11

  // receiver
  logic [1:0]    rxq;
  logic          rxs;
  rx_st_t        st;
  logic [OW-1:0] rx_tc;
  logic [2:0]    rx_bit;
  logic [7:0]    rx_sh;
  logic          rx_fin, rx_brk, rx_busy;

  assign rxs     = rxq[1];
  assign rx_busy = st == R_DATA || st == R_STOP;
  assign rx_fin  = st == R_STOP && tick && rx_tc == OW'(OVS - 1);
  assign rx_brk  = !rxs && rx_sh == 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxq <= 2'b11; st <= R_IDLE; rx_tc <= '0; rx_bit <= '0; rx_sh <= '0;
    end else begin
      rxq <= {rxq[0], rx_i};
      case (st)
        R_IDLE: if (!rxs) begin st <= R_START; rx_tc <= '0; end
        R_START: if (tick) begin
          if (rx_tc == OW'(MID)) begin
            rx_tc <= '0; rx_bit <= '0;
            st    <= rxs ? R_IDLE : R_DATA;
          end else rx_tc <= rx_tc + 1'b1;
        end
        R_DATA: if (tick) begin
          if (rx_tc == OW'(OVS - 1)) begin
            rx_tc  <= '0;
            rx_sh  <= {rxs, rx_sh[7:1]};
            rx_bit <= rx_bit + 1'b1;
            if (rx_bit == 3'd7) st <= R_STOP;
          end else rx_tc <= rx_tc + 1'b1;
        end
        R_STOP: if (tick) begin
          if (rx_tc == OW'(OVS - 1)) st <= rxs ? R_IDLE : R_WAIT;
          else rx_tc <= rx_tc + 1'b1;
        end
        default: if (rxs) st <= R_IDLE;
      endcase
    end

  // receive queue: {break, framing error, data}
  logic [9:0]    rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic          rx_full, rx_push, rx_rdy;
  logic [9:0]    head;

  assign rx_full = rx_cnt >= cap;
  assign rx_push = rx_fin && !rx_full;
  assign rx_rdy  = rx_cnt != '0;
  assign rd_data = reg_rd && reg_addr == 2'd0 && rx_rdy;
  assign head    = rx_mem[rx_rp];

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= {rx_brk, !rxs, rx_sh};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rd_data) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rd_data);
    end

  assign rtr_o = !(rx_busy ? (rx_cnt >= cap - CW'(1)) : (rx_cnt >= cap));

  AST_RX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH)); // R6
  AST_RX_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fin && rx_full && !rd_data && !wr_ctrl) |=> rx_cnt == $past(rx_cnt)); // R6
  AST_RTR_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt >= cap) |-> !rtr_o); // R8

  // status flags
  logic brk_imm, ovr_imm, thr;
  logic [7:0] stat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      brk_imm <= 1'b0; ovr_imm <= 1'b0; thr <= 1'b1;
    end else begin
      brk_imm <= (brk_imm && !(wr_stat && reg_wdata[5])) || (rx_fin && rx_brk);
      ovr_imm <= (ovr_imm && !(wr_stat && reg_wdata[6])) || (rx_fin && rx_full);
      thr     <= (thr && !(wr_stat && reg_wdata[2])) ||
                 (CW'(DEPTH) - tx_cnt >= CW'(HALF));
    end

  AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_imm && !(wr_stat && reg_wdata[5])) |=> brk_imm); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_imm && !(wr_stat && reg_wdata[6])) |=> ovr_imm); // R7

  assign stat = {tx_full, ovr_imm, brk_imm, rx_rdy && head[9], rx_rdy && head[8],
                 thr, tx_cnt == '0 && !tx_busy, rx_rdy};

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = rx_rdy ? head[7:0] : 8'h00;
      2'd1:    reg_rdata = stat;
      2'd2:    reg_rdata = ctrl;
      default: reg_rdata = 8'h00;
    endcase

  assign irq_o = |(ctrl[7:4] & {ovr_imm, brk_imm, thr, rx_rdy});
endmodule

// File: tb/fc_uart_bench.sv
module fc_uart_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] divisor = 16'd0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic rx_i = 1'b1, cts_i = 1'b1;
  logic tx_o, rtr_o, irq_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fc_uart u_fc_uart (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_i(rx_i), .tx_o(tx_o), .cts_i(cts_i), .rtr_o(rtr_o), .irq_o(irq_o));

  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{
    {8'h55, 8'h55}, {8'hA3, 8'hA3}, {8'h00, 8'h00},
    {8'hFF, 8'hFF}, {8'h81, 8'h81}, {8'h3C, 8'h3C}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b);
    @(negedge clk); rx_i = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      repeat (16) @(negedge clk);
    end
    rx_i = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic capture(output logic [7:0] b, output logic ok);
    int n = 0;
    ok = 1'b1; b = 8'h00;
    while (tx_o !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) ok = 1'b0;
    repeat (8) @(negedge clk);
    if (tx_o !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      b[i] = tx_o;
    end
    repeat (16) @(negedge clk);
    if (tx_o !== 1'b1) ok = 1'b0;
  endtask

  task automatic idle_for(input int n, output logic stayed);
    stayed = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_o !== 1'b1) stayed = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, st, g;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 tx_o", tx_o, 1); check("R1 rtr_o", rtr_o, 1); check("R1 irq_o", irq_o, 0);
    reg_read(2'd1, st); check("R1 status", st, 8'h06);

    // vector walk: transmit then receive each byte (R2, R3)
    for (int k = 0; k < NV; k++) begin
      reg_write(2'd0, VEC[k][15:8]);
      capture(g, ok);
      check("R2 tx frame data", g, VEC[k][7:0]); check("R2 tx framing", ok, 1);
      send_frame(VEC[k][15:8]);
      reg_read(2'd1, st); check("R3 rx ready", st[0], 1);
      reg_read(2'd0, d);  check("R3 rx data", d, VEC[k][7:0]);
    end

    // R4 short glitch
    @(negedge clk); rx_i = 1'b0; repeat (4) @(negedge clk); rx_i = 1'b1;
    repeat (200) @(negedge clk);
    reg_read(2'd1, st); check("R4 glitch rejected", st[0], 0);

    // R8 / R6 fill the receive queue
    for (int i = 0; i < 15; i++) send_frame(8'hA0 + 8'(i));
    check("R8 rtr with room", rtr_o, 1);
    fork
      send_frame(8'hAF);
      begin repeat (24) @(negedge clk); check("R8 rtr drops at last start", rtr_o, 0); end
    join
    check("R8 rtr while full", rtr_o, 0);
    send_frame(8'h77);
    reg_read(2'd1, st); check("R6 overrun flag", st[6], 1);
    reg_read(2'd0, d); check("R6 head intact", d, 8'hA0);
    check("R8 rtr after read", rtr_o, 1);
    for (int i = 1; i < 16; i++) begin
      reg_read(2'd0, d); check("R3 order", d, 8'hA0 + 8'(i));
    end
    reg_read(2'd1, st); check("R6 overrun char dropped", st[0], 0);
    check("R7 overrun sticky after reads", st[6], 1);
    reg_write(2'd1, 8'h40);
    reg_read(2'd1, st); check("R7 overrun cleared", st[6], 0);

    // R9 queues disabled
    reg_write(2'd2, 8'h00);
    fork
      send_frame(8'h3E);
      begin repeat (40) @(negedge clk); check("R9 rtr drops in frame", rtr_o, 0); end
    join
    repeat (20) @(negedge clk);
    check("R9 rtr held until read", rtr_o, 0);
    reg_read(2'd0, d); check("R9 data", d, 8'h3E);
    check("R9 rtr after read", rtr_o, 1);
    reg_write(2'd2, 8'h41);

    // R5 / R7 / R13 break
    send_frame(8'h41);
    @(negedge clk); rx_i = 1'b0; repeat (160) @(negedge clk); rx_i = 1'b1;
    repeat (32) @(negedge clk);
    reg_read(2'd1, st); check("R5 immediate break, head flags clear", st & 8'h39, 8'h21);
    check("R13 irq on break", irq_o, 1);
    reg_read(2'd0, d); check("R5 head char", d, 8'h41);
    reg_read(2'd1, st); check("R5 break and framing at head", st & 8'h38, 8'h38);
    reg_read(2'd0, d); check("R5 break char", d, 8'h00);
    reg_read(2'd1, st); check("R7 break sticky", st[5], 1);
    reg_write(2'd1, 8'h20);
    reg_read(2'd1, st); check("R7 break cleared", st[5], 0);
    check("R13 irq cleared", irq_o, 0);
    reg_write(2'd2, 8'h11);
    send_frame(8'h12);
    check("R13 irq on rx ready", irq_o, 1);
    reg_read(2'd0, d);
    reg_write(2'd2, 8'h01);

    // R10 clear-to-send
    cts_i = 1'b0;
    reg_write(2'd0, 8'h5A);
    idle_for(300, ok); check("R10 held while cts low", ok, 1);
    cts_i = 1'b1;
    fork
      capture(g, ok);
      begin repeat (40) @(negedge clk); cts_i = 1'b0; end
    join
    check("R10 frame completes", g, 8'h5A); check("R10 framing", ok, 1);
    reg_write(2'd0, 8'hC3);
    idle_for(200, ok); check("R10 no new start", ok, 1);
    cts_i = 1'b1;
    capture(g, ok); check("R10 resumed frame", g, 8'hC3);

    // R11 / R12 transmit queue depth and threshold
    repeat (20) @(negedge clk);
    cts_i = 1'b0;
    for (int i = 0; i < 16; i++) reg_write(2'd0, 8'h10 + 8'(i));
    reg_read(2'd1, st); check("R11 full", st[7], 1); check("R11 not empty", st[1], 0);
    reg_write(2'd0, 8'hEE);
    reg_write(2'd1, 8'h04);
    reg_read(2'd1, st); check("R12 threshold cleared", st[2], 0);
    cts_i = 1'b1;
    for (int k = 0; k < 16; k++) begin
      capture(g, ok);
      check("R11 queued order", g, 8'h10 + 8'(k));
      if (k == 6) begin reg_read(2'd1, st); check("R12 nine queued", st[2], 0); end
      if (k == 7) begin reg_read(2'd1, st); check("R12 eight free", st[2], 1); end
    end
    idle_for(300, ok); check("R11 dropped write not sent", ok, 1);
    reg_read(2'd1, st); check("R11 empty after drain", st[1], 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule